// File: doc/BRIEF.md
# ADC Result Threshold Counter

This block sits beside an ADC result path and inspects each two's-complement conversion result as it arrives, qualified by a valid strobe. It forms the unsigned magnitude of the sample and compares that magnitude with a programmable threshold. Two things follow from the comparison. A comparator event is flagged when the magnitude is strictly above the threshold. An 8-bit occurrence counter moves up when the magnitude is at or above the threshold, and moves down or drops to zero otherwise, depending on the configured mode.

A second event is flagged when a counter update lands exactly on a programmable limit. Both event flags drive interrupt outputs and stay set until software clears them with a write-one-to-clear access. A small word-wide register port holds the control bits, the threshold and the limit. It also returns the counter and the flags on reads.

Top module: `adc_thresh_counter`

## Requirements
- R1: After reset the counter, both flags, the control bits, the threshold and the limit all read as zero, and both interrupt outputs are low.
- R2: The magnitude of a sample is its absolute value as a DATA_W-bit unsigned number. The most negative code (0x8000 at the default width) gives magnitude 0x8000, with no overflow.
- R3: When the counter is enabled, each valid sample whose magnitude is greater than or equal to the threshold adds one to the counter. The new value is visible from the clock edge that takes the sample.
- R4: When the counter is enabled, each valid sample whose magnitude is below the threshold lowers the counter by one if control bit 2 is 0. It sets the counter to zero if control bit 2 is 1.
- R5: The counter saturates: an increment at 0xFF leaves 0xFF, and a decrement at 0x00 leaves 0x00.
- R6: When control bit 0 (comparator enable) is 1, a valid sample whose magnitude is strictly greater than the threshold sets the comparator flag, bit 0 of the flags register. A magnitude equal to the threshold does not set it. The flag drives irq_cmp_o.
- R7: A counter update whose new value equals the limit register sets the limit flag, bit 1 of the flags register. The flag drives irq_cnt_o.
- R8: Samples with the valid strobe low are ignored. With control bit 1 (counter enable) at 0 the counter holds its value. With control bit 0 at 0 the comparator flag is not set.
- R9: Writing the flags register (address 4) clears each flag whose written bit is 1. A flag being set in the same cycle as it is cleared stays set.
- R10: The counter register (address 3) is read-only, and writes to it have no effect.
- R11: The register map is: address 0 holds the control bits [2:0], address 1 holds the threshold, address 2 holds the limit [7:0], address 3 holds the counter and address 4 holds the flags. Reads are combinational, and unmapped addresses read zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset, released synchronously inside |
| smp_valid_i | input | 1 | Sample qualifier |
| smp_data_i | input | DATA_W | Two's-complement conversion result |
| reg_we_i | input | 1 | Register write strobe |
| reg_addr_i | input | 3 | Register address |
| reg_wdata_i | input | DATA_W | Register write data |
| reg_rdata_o | output | DATA_W | Register read data for reg_addr_i |
| irq_cmp_o | output | 1 | Sticky comparator interrupt |
| irq_cnt_o | output | 1 | Sticky counter-limit interrupt |

## Verification
The bench targets a sample whose magnitude equals the threshold. A design that used the wrong comparison there would either fail to count the sample or raise the comparator flag too early. It drives the most negative code against thresholds of 0x8000 and 0x7FFF, which exposes a magnitude that overflows to zero or reads as negative. Long runs of samples push the counter past 0xFF and below 0x00, so a counter that wraps shows up at once. A flag set and cleared in the same cycle, writes to the read-only counter, and samples taken with the valid strobe low or with an enable off each catch a design that lets the wrong event through.

// File: rtl/atc_pkg.sv
package atc_pkg;
  localparam int ADDR_W = 3;

  localparam logic [ADDR_W-1:0] A_CTRL   = 3'd0;
  localparam logic [ADDR_W-1:0] A_THRESH = 3'd1;
  localparam logic [ADDR_W-1:0] A_LIMIT  = 3'd2;
  localparam logic [ADDR_W-1:0] A_COUNT  = 3'd3;
  localparam logic [ADDR_W-1:0] A_FLAGS  = 3'd4;

  typedef struct packed {
    logic clr_mode;  // bit 2: below-threshold clears instead of decrementing
    logic cnt_en;    // bit 1
    logic cmp_en;    // bit 0
  } atc_ctrl_t;

  localparam int CTRL_W = $bits(atc_ctrl_t);

  typedef struct packed {
    logic lim;   // bit 1
    logic cmp;   // bit 0
  } atc_flags_t;
endpackage

// File: rtl/atc_magnitude.sv
module atc_magnitude #(
  parameter int DATA_W = 16
) (
  input  logic [DATA_W-1:0] smp_i,
  input  logic [DATA_W-1:0] thresh_i,
  output logic [DATA_W-1:0] mag_o,
  output logic              ge_o,
  output logic              gt_o
);
  // two's-complement negate fits unsigned DATA_W bits even for the most negative code
  always_comb begin
    if (smp_i[DATA_W-1]) begin
      mag_o = (~smp_i) + {{(DATA_W-1){1'b0}}, 1'b1};
    end else begin
      mag_o = smp_i;
    end
    ge_o = (mag_o >= thresh_i);
    gt_o = (mag_o >  thresh_i);
  end
endmodule

// File: rtl/atc_occ_counter.sv
module atc_occ_counter #(
  parameter int CNT_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             upd_i,
  input  logic             ge_i,
  input  logic             clr_mode_i,
  input  logic [CNT_W-1:0] limit_i,
  output logic [CNT_W-1:0] count_o,
  output logic             reach_o
);
  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};
  localparam logic [CNT_W-1:0] CNT_ONE = {{(CNT_W-1){1'b0}}, 1'b1};

  logic [CNT_W-1:0] cnt_q, cnt_d;

  always_comb begin
    cnt_d = cnt_q;
    if (ge_i) begin
      if (cnt_q != CNT_MAX) cnt_d = cnt_q + CNT_ONE;
    end else if (clr_mode_i) begin
      cnt_d = '0;
    end else if (cnt_q != '0) begin
      cnt_d = cnt_q - CNT_ONE;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
    end else if (upd_i) begin
      cnt_q <= cnt_d;
    end
  end

  assign reach_o = upd_i && (cnt_d == limit_i);
  assign count_o = cnt_q;
endmodule

// File: rtl/atc_regs.sv
module atc_regs
  import atc_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int CNT_W  = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o,
  input  logic [CNT_W-1:0]  count_i,
  input  logic              set_cmp_i,
  input  logic              set_lim_i,
  output atc_ctrl_t         ctrl_o,
  output logic [DATA_W-1:0] thresh_o,
  output logic [CNT_W-1:0]  limit_o,
  output atc_flags_t        flags_o
);
  atc_ctrl_t         ctrl_q, ctrl_d;
  logic [DATA_W-1:0] thr_q, thr_d;
  logic [CNT_W-1:0]  lim_q, lim_d;
  atc_flags_t        flg_q, flg_d;
  logic              wr_ctrl, wr_thr, wr_lim, wr_flg;

  always_comb begin
    wr_ctrl = we_i && (addr_i == A_CTRL);
    wr_thr  = we_i && (addr_i == A_THRESH);
    wr_lim  = we_i && (addr_i == A_LIMIT);
    wr_flg  = we_i && (addr_i == A_FLAGS);

    ctrl_d = wr_ctrl ? atc_ctrl_t'(wdata_i[CTRL_W-1:0]) : ctrl_q;
    thr_d  = wr_thr  ? wdata_i : thr_q;
    lim_d  = wr_lim  ? wdata_i[CNT_W-1:0] : lim_q;

    flg_d = flg_q;
    if (wr_flg) begin
      if (wdata_i[0]) flg_d.cmp = 1'b0;
      if (wdata_i[1]) flg_d.lim = 1'b0;
    end
    if (set_cmp_i) flg_d.cmp = 1'b1;
    if (set_lim_i) flg_d.lim = 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctrl_q <= '0;
      thr_q  <= '0;
      lim_q  <= '0;
      flg_q  <= '0;
    end else begin
      ctrl_q <= ctrl_d;
      thr_q  <= thr_d;
      lim_q  <= lim_d;
      flg_q  <= flg_d;
    end
  end

  always_comb begin
    rdata_o = '0;
    unique case (addr_i)
      A_CTRL:   rdata_o[CTRL_W-1:0] = ctrl_q;
      A_THRESH: rdata_o = thr_q;
      A_LIMIT:  rdata_o[CNT_W-1:0] = lim_q;
      A_COUNT:  rdata_o[CNT_W-1:0] = count_i;
      A_FLAGS:  rdata_o[1:0] = flg_q;
      default:  rdata_o = '0;
    endcase
  end

  assign ctrl_o   = ctrl_q;
  assign thresh_o = thr_q;
  assign limit_o  = lim_q;
  assign flags_o  = flg_q;
endmodule

// File: rtl/adc_thresh_counter.sv
module adc_thresh_counter
  import atc_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int CNT_W  = 8
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 smp_valid_i,
  input  logic [DATA_W-1:0]    smp_data_i,
  input  logic                 reg_we_i,
  input  logic [ADDR_W-1:0]    reg_addr_i,
  input  logic [DATA_W-1:0]    reg_wdata_i,
  output logic [DATA_W-1:0]    reg_rdata_o,
  output logic                 irq_cmp_o,
  output logic                 irq_cnt_o
);
  // reset: asserted asynchronously, released through two flops
  logic [1:0] rst_sync_q;
  logic       rst_n;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) rst_sync_q <= 2'b00;
    else         rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_n = rst_sync_q[1];

  atc_ctrl_t         ctrl;
  logic [DATA_W-1:0] thresh;
  logic [CNT_W-1:0]  limit;
  logic [CNT_W-1:0]  count;
  atc_flags_t        flags;
  logic [DATA_W-1:0] mag;
  logic              ge, gt, upd, reach, set_cmp;
  logic              cmp_en, cnt_en, clr_mode;

  assign cmp_en   = ctrl.cmp_en;
  assign cnt_en   = ctrl.cnt_en;
  assign clr_mode = ctrl.clr_mode;

  atc_magnitude #(.DATA_W(DATA_W)) i_mag (
    .smp_i    (smp_data_i),
    .thresh_i (thresh),
    .mag_o    (mag),
    .ge_o     (ge),
    .gt_o     (gt)
  );

  assign upd     = smp_valid_i && cnt_en;
  assign set_cmp = smp_valid_i && cmp_en && gt;

  atc_occ_counter #(.CNT_W(CNT_W)) i_cnt (
    .clk_i      (clk_i),
    .rst_ni     (rst_n),
    .upd_i      (upd),
    .ge_i       (ge),
    .clr_mode_i (clr_mode),
    .limit_i    (limit),
    .count_o    (count),
    .reach_o    (reach)
  );

  atc_regs #(.DATA_W(DATA_W), .CNT_W(CNT_W)) i_regs (
    .clk_i     (clk_i),
    .rst_ni    (rst_n),
    .we_i      (reg_we_i),
    .addr_i    (reg_addr_i),
    .wdata_i   (reg_wdata_i),
    .rdata_o   (reg_rdata_o),
    .count_i   (count),
    .set_cmp_i (set_cmp),
    .set_lim_i (reach),
    .ctrl_o    (ctrl),
    .thresh_o  (thresh),
    .limit_o   (limit),
    .flags_o   (flags)
  );

  assign irq_cmp_o = flags.cmp;
  assign irq_cnt_o = flags.lim;
endmodule

// File: rtl/atc_checker.sv
module atc_checker #(
  parameter int CNT_W = 8
) (
  input logic             clk_i,
  input logic             rst_n,
  input logic             smp_valid_i,
  input logic             cmp_en,
  input logic             upd,
  input logic             ge,
  input logic             clr_mode,
  input logic [CNT_W-1:0] count,
  input logic [CNT_W-1:0] limit,
  input logic             irq_cmp_o,
  input logic             irq_cnt_o
);
  // R8: no update request, counter keeps its value
  p_hold_r8: assert property (@(posedge clk_i) disable iff (!rst_n)
    !upd |=> $stable(count));

  // R5: no wrap at the top
  p_no_wrap_up_r5: assert property (@(posedge clk_i) disable iff (!rst_n)
    (upd && ge && count == {CNT_W{1'b1}}) |=> count == {CNT_W{1'b1}});

  // R5: no wrap at the bottom
  p_no_wrap_dn_r5: assert property (@(posedge clk_i) disable iff (!rst_n)
    (upd && !ge && count == '0) |=> count == '0);

  // R4: clear mode sends the counter to zero
  p_clear_r4: assert property (@(posedge clk_i) disable iff (!rst_n)
    (upd && !ge && clr_mode) |=> count == '0);

  // R6: comparator flag rises only after an enabled valid sample
  p_cmp_src_r6: assert property (@(posedge clk_i) disable iff (!rst_n)
    $rose(irq_cmp_o) |-> $past(smp_valid_i && cmp_en));

  // R7: limit flag rises only when the counter landed on the limit
  p_lim_src_r7: assert property (@(posedge clk_i) disable iff (!rst_n)
    $rose(irq_cnt_o) |-> ($past(upd) && count == $past(limit)));
endmodule

bind adc_thresh_counter atc_checker #(.CNT_W(CNT_W)) i_atc_checker (
  .clk_i       (clk_i),
  .rst_n       (rst_n),
  .smp_valid_i (smp_valid_i),
  .cmp_en      (cmp_en),
  .upd         (upd),
  .ge          (ge),
  .clr_mode    (clr_mode),
  .count       (count),
  .limit       (limit),
  .irq_cmp_o   (irq_cmp_o),
  .irq_cnt_o   (irq_cnt_o)
);

// File: tb/test_adc_thresh_counter.sv
module test_adc_thresh_counter;
  localparam int DW = 16;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          v;
  logic [DW-1:0] d;
  logic          we;
  logic [2:0]    a;
  logic [DW-1:0] wd;
  logic [DW-1:0] rd;
  logic          irq_c, irq_n;

  int n_chk = 0;
  int n_bad = 0;
  bit done  = 1'b0;

  // bench model
  logic [2:0]    m_ctrl;
  logic [DW-1:0] m_th;
  logic [7:0]    m_lim;
  logic [7:0]    m_cnt;
  logic          m_fc, m_fn;

  always #5 clk = ~clk;

  adc_thresh_counter #(.DATA_W(DW), .CNT_W(8)) i_adc_thresh_counter (
    .clk_i(clk), .rst_ni(rst_n), .smp_valid_i(v), .smp_data_i(d),
    .reg_we_i(we), .reg_addr_i(a), .reg_wdata_i(wd), .reg_rdata_o(rd),
    .irq_cmp_o(irq_c), .irq_cnt_o(irq_n)
  );

  function automatic logic [DW-1:0] f_mag(input logic [DW-1:0] x);
    logic [DW:0] t;
    if (x[DW-1]) t = (1 << DW) - {1'b0, x};
    else         t = {1'b0, x};
    return t[DW-1:0];
  endfunction

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic apply(input logic iv, input logic [DW-1:0] id, input logic iwe,
                       input logic [2:0] ia, input logic [DW-1:0] iwd, input string req);
    logic [DW-1:0] mg;
    logic [7:0]    nc;
    v = iv; d = id; we = iwe; a = ia; wd = iwd;
    @(posedge clk);
    mg = f_mag(id);
    begin
      logic sc, sn;
      sc = iv && m_ctrl[0] && (mg > m_th);
      sn = 1'b0;
      if (iv && m_ctrl[1]) begin
        if (mg >= m_th)     nc = (m_cnt == 8'hFF) ? 8'hFF : m_cnt + 8'd1;
        else if (m_ctrl[2]) nc = 8'h00;
        else                nc = (m_cnt == 8'h00) ? 8'h00 : m_cnt - 8'd1;
        sn = (nc == m_lim);
        m_cnt = nc;
      end
      if (iwe && ia == 3'd4) begin
        if (iwd[0]) m_fc = 1'b0;
        if (iwd[1]) m_fn = 1'b0;
      end
      if (sc) m_fc = 1'b1;
      if (sn) m_fn = 1'b1;
      if (iwe) begin
        case (ia)
          3'd0: m_ctrl = iwd[2:0];
          3'd1: m_th   = iwd;
          3'd2: m_lim  = iwd[7:0];
          default: ;
        endcase
      end
    end
    @(negedge clk);
    v = 1'b0; we = 1'b0; a = 3'd3;
    #1;
    chk(rd[7:0] == m_cnt && rd[DW-1:8] == '0, {req, " count"}, rd, m_cnt);
    chk(irq_c == m_fc, {req, " irq_cmp"}, irq_c, m_fc);
    chk(irq_n == m_fn, {req, " irq_cnt"}, irq_n, m_fn);
  endtask

  task automatic wr(input logic [2:0] ia, input logic [DW-1:0] iwd, input string req);
    apply(1'b0, '0, 1'b1, ia, iwd, req);
  endtask

  task automatic smp(input logic [DW-1:0] id, input string req);
    apply(1'b1, id, 1'b0, 3'd0, '0, req);
  endtask

  task automatic rdchk(input logic [2:0] ia, input logic [DW-1:0] exp, input string req);
    a = ia; #1;
    chk(rd == exp, req, rd, exp);
  endtask

  initial begin
    #(10 * 150000);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog actual=0x0 expected=0x1");
      $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    v = 0; d = '0; we = 0; a = 3'd0; wd = '0;
    m_ctrl = '0; m_th = '0; m_lim = '0; m_cnt = '0; m_fc = 0; m_fn = 0;
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1 and R11: reset values and read map
    rdchk(3'd0, '0, "R1 ctrl");
    rdchk(3'd1, '0, "R1 thresh");
    rdchk(3'd2, '0, "R1 limit");
    rdchk(3'd3, '0, "R1 count");
    rdchk(3'd4, '0, "R1 flags");
    rdchk(3'd6, '0, "R11 unmapped");
    chk(irq_c == 1'b0 && irq_n == 1'b0, "R1 irqs", {irq_c, irq_n}, 0);

    // R11: configuration write and readback
    wr(3'd0, 16'h0003, "R11");
    wr(3'd1, 16'd100, "R11");
    wr(3'd2, 16'h0003, "R11");
    rdchk(3'd0, 16'h0003, "R11 ctrl readback");
    rdchk(3'd1, 16'd100, "R11 thresh readback");
    rdchk(3'd2, 16'h0003, "R11 limit readback");

    smp(16'hFF9C, "R3 R2 equal magnitude");   // -100: counts, no comparator flag
    smp(16'd101, "R6 above");
    smp(16'hFF9B, "R7 reach limit");         // count hits 3
    rdchk(3'd4, 16'h0003, "R9 flags readback");
    wr(3'd4, 16'h0001, "R9 clear cmp only");
    wr(3'd4, 16'h0002, "R9 clear lim");
    smp(16'd99, "R4 decrement");
    wr(3'd3, 16'h0055, "R10 write count ignored");
    apply(1'b0, 16'd5000, 1'b0, 3'd0, '0, "R8 invalid ignored");
    wr(3'd0, 16'h0001, "R8");
    smp(16'd500, "R8 counter disabled");
    wr(3'd4, 16'h0001, "R9");
    wr(3'd0, 16'h0000, "R8");
    smp(16'd500, "R8 all disabled");

    // R4 clear mode
    wr(3'd0, 16'h0007, "R4");
    smp(16'd150, "R4");
    smp(16'd50, "R4 clear mode");
    // R2 most negative code
    wr(3'd1, 16'h8000, "R2");
    smp(16'h8000, "R2 min code equals 0x8000");
    wr(3'd1, 16'h7FFF, "R2");
    smp(16'h8000, "R2 min code above 0x7FFF");
    // R9 set beats clear in same cycle
    apply(1'b1, 16'h8000, 1'b1, 3'd4, 16'h0003, "R9 set wins");

    // R5 saturation both ends
    wr(3'd2, 16'h0000, "R5");
    wr(3'd1, 16'h0000, "R5");
    wr(3'd0, 16'h0002, "R5");
    for (int i = 0; i < 262; i++) smp(16'(i), "R5 saturate high");
    wr(3'd1, 16'hFFFF, "R5");
    for (int i = 0; i < 262; i++) smp(16'(i * 7), "R5 saturate low");

    // mixed random
    for (int i = 0; i < 4000; i++) begin
      int unsigned sel;
      logic [DW-1:0] dv;
      sel = $urandom % 10;
      if (sel == 0) begin
        logic [2:0] ra;
        logic [DW-1:0] rv;
        ra = 3'($urandom % 6);
        rv = 16'($urandom);
        if (ra == 3'd1) rv = 16'($urandom % 400);
        if (ra == 3'd2) rv = 16'($urandom % 12);
        apply(1'($urandom), 16'($urandom), 1'b1, ra, rv, "R3 R4 R6 R7 R9 random");
      end else begin
        case ($urandom % 4)
          0: dv = 16'($urandom);
          1: dv = m_th;
          2: dv = ($urandom % 2) ? 16'h8000 : 16'h7FFF;
          default: dv = m_th + 16'($urandom % 3) - 16'd1;
        endcase
        if ($urandom % 2) dv = -dv;
        apply(($urandom % 8) != 0, dv, 1'b0, 3'd0, '0, "R3 R4 R5 R6 R7 R8 random");
      end
    end

    done = 1'b1;
    $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule